// File: doc/BRIEF.md
# Interrupt Packet Dispatcher

This block sits behind the link sequencer of a power-management controller link. Each interrupt packet, from 1 to 32 bytes long, is written into a local buffer one byte per cycle. Once the last byte is in, a state machine reads the first byte and the length, decides where the packet belongs, and dispatches it. A packet may be a deferred reply to a command that is still waiting for one. It may be an unsolicited input event for the peripheral-bus event stream. It may be a front-panel button event that carries a new backlight level and volume. A periodic tick is dropped without notice. Anything else is reported on a debug port. A zero-length packet only clears the pending-interrupt condition.

A button event produces a volume update at once. When the backlight is enabled, it also produces two follow-up commands in sequence. The first sets the brightness, using a code derived from the level. The second is a power-control command that switches the backlight on or off. Each follow-up kind has its own issue slot. A slot sends nothing new until the consumer reports the previous command done. While it waits it keeps only the newest request.

The dispatcher states are COLLECT, CLASSIFY, REPLY, EVENT, BUTTON and BL_POWER. The transitions are:
- COLLECT→CLASSIFY when the last byte is written.
- CLASSIFY→REPLY for a deferred reply longer than 2 bytes while a request is waiting.
- CLASSIFY→EVENT for an unsolicited packet longer than 1 byte.
- CLASSIFY→BUTTON for a button event.
- CLASSIFY→COLLECT in every other case.
- REPLY→COLLECT and EVENT→COLLECT after the final byte.
- BUTTON→BL_POWER when the backlight is enabled, otherwise BUTTON→COLLECT.
- BL_POWER→COLLECT.

Each follow-up slot has two states, SL_IDLE and SL_FLIGHT. A slot moves from SL_IDLE to SL_FLIGHT when it issues a command. It returns to SL_IDLE when done arrives and nothing is queued.

Top module: `irq_pkt_dispatch`

## Requirements
- R1: Asserting `in_empty` while COLLECT holds no bytes produces exactly one `pend_clr` pulse, one cycle later. It produces no other output.
- R2: Byte 0 is the flag byte. If its bus flag (bit 4) is 1 and its autopoll flag (bit 2) is 0, the packet is a deferred reply. When `awaiting` is 1, the reply is delivered and `awaiting` returns to 0.
- R3: A deferred reply of total length N ≤ 2 gives one `rep_done` with `rep_len`=0 and no bytes. For N > 2, bytes 1..N-1 appear in order on `rep_byte`, and `rep_done` comes with the final byte, where `rep_len`=N-1.
- R4: A deferred reply that arrives while `awaiting` is 0 gives one `err_extra` pulse. It gives no reply output, and `awaiting` stays 0.
- R5: If bits 4 and 2 of byte 0 are both 1, bytes 1..N-1 appear in order on `evt_byte`, and `evt_last` marks the final one. `awaiting` is not changed.
- R6: A packet of exactly 3 bytes with byte 0 = 0x08 is a button event. It gives one `vol_valid` with `vol_level` equal to byte 2. Its backlight level is byte 1 shifted right by 3.
- R7: The brightness code is 0x7F for level 0. For any other level it is 0x4A minus twice the level, so level 31 gives 0x0C.
- R8: With `bl_enable` at 1, a button event issues a brightness command carrying that code. One cycle later it requests a power command, with `pwr_cmd_on`=1 exactly when the code is below 0x7F. With `bl_enable` at 0, neither command is issued.
- R9: A slot that has issued a command issues nothing more until its done input pulses. A done pulse then issues only the newest request queued meanwhile, or nothing if none was queued.
- R10: A 1-byte packet of 0x80 (tick) is ignored. Any other packet that matches no class gives one `dbg_valid` with `dbg_code` equal to byte 0.
- R11: `busy` is 1 from the cycle after the last byte until dispatch returns to COLLECT. `await_set` sets `awaiting` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet byte is valid |
| in_byte | input | 8 | Packet byte |
| in_last | input | 1 | Final byte of the packet |
| in_empty | input | 1 | Zero-length packet completed |
| await_set | input | 1 | A command now expects a deferred reply |
| bl_enable | input | 1 | Backlight control is enabled |
| bri_done | input | 1 | Brightness command completed |
| pwr_done | input | 1 | Power command completed |
| busy | output | 1 | Dispatch in progress; no bytes accepted |
| awaiting | output | 1 | A request awaits its deferred reply |
| pend_clr | output | 1 | Pending-interrupt clear pulse |
| err_extra | output | 1 | Deferred reply with no request waiting |
| dbg_valid | output | 1 | Unclassified packet seen |
| dbg_code | output | 8 | Byte 0 of the unclassified packet |
| rep_valid | output | 1 | Reply byte valid |
| rep_byte | output | 8 | Reply byte |
| rep_done | output | 1 | Reply complete |
| rep_len | output | 6 | Number of reply bytes delivered |
| evt_valid | output | 1 | Input-event byte valid |
| evt_byte | output | 8 | Input-event byte |
| evt_last | output | 1 | Final input-event byte |
| vol_valid | output | 1 | Volume update valid |
| vol_level | output | 8 | Volume value |
| bri_cmd_valid | output | 1 | Brightness command issue pulse |
| bri_cmd_code | output | 8 | Brightness code |
| pwr_cmd_valid | output | 1 | Power command issue pulse |
| pwr_cmd_on | output | 1 | Power command switches backlight on |

## Verification
The assertions assume that the link sequencer respects `busy`. No byte and no empty marker arrives while it is 1, and no packet is longer than 32 bytes. They also assume that a done pulse is raised only for a slot that has a command in flight. The directed tasks keep to these rules. Each task waits a fixed number of idle cycles after its last byte, well past the longest dispatch. Each task also pulses done only after the matching command has been observed.

// File: rtl/irq_pkt_pkg.sv
package irq_pkt_pkg;

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_CLASSIFY,
        ST_REPLY,
        ST_EVENT,
        ST_BUTTON,
        ST_BL_POWER
    } disp_state_e;

    typedef enum logic {
        SL_IDLE,
        SL_FLIGHT
    } slot_state_e;

endpackage

// File: rtl/pkt_buffer.sv
module pkt_buffer #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    parameter int NTAP  = 3,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [AW-1:0]            raddr,
    output logic [DW-1:0]            rdata,
    output logic [NTAP-1:0][DW-1:0]  taps
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // fixed header taps used for classification
    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign taps[g] = mem[g];
    end
endmodule

// File: rtl/bright_map.sv
module bright_map #(
    parameter int             DW        = 8,
    parameter int             LVW       = 5,
    parameter logic [DW-1:0]  OFF_CODE  = 8'h7F,
    parameter logic [DW-1:0]  BASE_CODE = 8'h4A
) (
    input  logic [LVW-1:0] level,
    output logic [DW-1:0]  code,
    output logic           lamp_on
);
    logic [DW-1:0] twice;

    assign twice   = DW'({level, 1'b0});
    assign code    = (level == '0) ? OFF_CODE : (BASE_CODE - twice);
    assign lamp_on = (code < OFF_CODE);
endmodule

// File: rtl/fu_slot.sv
module fu_slot
    import irq_pkt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [W-1:0]  req_data,
    input  logic          done,
    output logic          cmd_valid,
    output logic [W-1:0]  cmd_data,
    output logic          in_flight
);
    slot_state_e st_q, st_d;
    logic         issue;
    logic [W-1:0] issue_data;
    logic [W-1:0] held_q;
    logic         pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SL_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d       = st_q;
        issue      = 1'b0;
        issue_data = req_data;
        unique case (st_q)
            SL_IDLE: begin
                if (req) begin
                    issue = 1'b1;
                    st_d  = SL_FLIGHT;
                end
            end
            SL_FLIGHT: begin
                if (done) begin
                    if (req) begin
                        issue = 1'b1;
                    end else if (pend_q) begin
                        issue      = 1'b1;
                        issue_data = held_q;
                    end else begin
                        st_d = SL_IDLE;
                    end
                end
            end
            default: st_d = SL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_data  <= '0;
            held_q    <= '0;
            pend_q    <= 1'b0;
        end else begin
            cmd_valid <= issue;
            if (issue) cmd_data <= issue_data;
            if (st_q == SL_FLIGHT && req && !done) begin
                held_q <= req_data;
                pend_q <= 1'b1;
            end else if (issue) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign in_flight = (st_q == SL_FLIGHT);

    a_r9_no_reissue_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flight && !done) |=> !cmd_valid);
endmodule

// File: rtl/irq_pkt_dispatch.sv
module irq_pkt_dispatch
    import irq_pkt_pkg::*;
#(
    parameter int            DW          = 8,
    parameter int            DEPTH       = 32,
    parameter int            BUS_BIT     = 4,
    parameter int            AUTO_BIT    = 2,
    parameter logic [7:0]    BUTTON_CODE = 8'h08,
    parameter logic [7:0]    TICK_CODE   = 8'h80,
    parameter logic [7:0]    OFF_CODE    = 8'h7F,
    parameter logic [7:0]    BASE_CODE   = 8'h4A,
    localparam int           AW          = $clog2(DEPTH),
    localparam int           LW          = $clog2(DEPTH + 1),
    localparam int           LVW         = DW - 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    input  logic          in_last,
    input  logic          in_empty,
    input  logic          await_set,
    input  logic          bl_enable,
    input  logic          bri_done,
    input  logic          pwr_done,
    output logic          busy,
    output logic          awaiting,
    output logic          pend_clr,
    output logic          err_extra,
    output logic          dbg_valid,
    output logic [DW-1:0] dbg_code,
    output logic          rep_valid,
    output logic [DW-1:0] rep_byte,
    output logic          rep_done,
    output logic [LW-1:0] rep_len,
    output logic          evt_valid,
    output logic [DW-1:0] evt_byte,
    output logic          evt_last,
    output logic          vol_valid,
    output logic [DW-1:0] vol_level,
    output logic          bri_cmd_valid,
    output logic [DW-1:0] bri_cmd_code,
    output logic          pwr_cmd_valid,
    output logic          pwr_cmd_on
);
    disp_state_e st_q, st_d;

    logic [LW-1:0] wr_cnt_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] rd_idx_q;
    logic [LW-1:0] last_idx;
    logic          awaiting_q;
    logic          pend_clr_q;

    logic                 buf_we;
    logic [DW-1:0]        buf_rdata;
    logic [2:0][DW-1:0]   taps;

    logic          is_bus, is_auto, is_button, is_tick, at_end;
    logic [DW-1:0] code;
    logic          lamp_on;
    logic          bri_req, pwr_req;
    logic          pwr_on_data;

    // ---------------- packet storage ----------------
    assign buf_we = (st_q == ST_COLLECT) && in_valid && (wr_cnt_q < LW'(DEPTH));

    pkt_buffer #(.DW(DW), .DEPTH(DEPTH), .NTAP(3)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (wr_cnt_q[AW-1:0]),
        .wdata (in_byte),
        .raddr (rd_idx_q[AW-1:0]),
        .rdata (buf_rdata),
        .taps  (taps)
    );

    // ---------------- classification ----------------
    assign is_bus    = taps[0][BUS_BIT];
    assign is_auto   = taps[0][AUTO_BIT];
    assign is_button = (taps[0] == BUTTON_CODE) && (len_q == LW'(3));
    assign is_tick   = (taps[0] == TICK_CODE) && (len_q == LW'(1));
    assign last_idx  = len_q - LW'(1);
    assign at_end    = (rd_idx_q == last_idx);

    bright_map #(.DW(DW), .LVW(LVW), .OFF_CODE(OFF_CODE), .BASE_CODE(BASE_CODE)) u_map (
        .level   (taps[1][DW-1:3]),
        .code    (code),
        .lamp_on (lamp_on)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_COLLECT;
        else        st_q <= st_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_COLLECT: begin
                if (in_valid && in_last) st_d = ST_CLASSIFY;
            end
            ST_CLASSIFY: begin
                if (is_bus && !is_auto) begin
                    st_d = (awaiting_q && len_q > LW'(2)) ? ST_REPLY : ST_COLLECT;
                end else if (is_bus) begin
                    st_d = (len_q > LW'(1)) ? ST_EVENT : ST_COLLECT;
                end else if (is_button) begin
                    st_d = ST_BUTTON;
                end else begin
                    st_d = ST_COLLECT;
                end
            end
            ST_REPLY:    if (at_end) st_d = ST_COLLECT;
            ST_EVENT:    if (at_end) st_d = ST_COLLECT;
            ST_BUTTON:   st_d = bl_enable ? ST_BL_POWER : ST_COLLECT;
            ST_BL_POWER: st_d = ST_COLLECT;
            default:     st_d = ST_COLLECT;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        err_extra = 1'b0;
        dbg_valid = 1'b0;
        rep_valid = 1'b0;
        rep_byte  = '0;
        rep_done  = 1'b0;
        rep_len   = '0;
        evt_valid = 1'b0;
        evt_byte  = '0;
        evt_last  = 1'b0;
        vol_valid = 1'b0;
        vol_level = '0;
        bri_req   = 1'b0;
        pwr_req   = 1'b0;
        unique case (st_q)
            ST_CLASSIFY: begin
                if (is_bus && !is_auto) begin
                    if (!awaiting_q)               err_extra = 1'b1;
                    else if (len_q <= LW'(2))      rep_done  = 1'b1;
                end else if (!is_bus && !is_button && !is_tick) begin
                    dbg_valid = 1'b1;
                end
            end
            ST_REPLY: begin
                rep_valid = 1'b1;
                rep_byte  = buf_rdata;
                if (at_end) begin
                    rep_done = 1'b1;
                    rep_len  = last_idx;
                end
            end
            ST_EVENT: begin
                evt_valid = 1'b1;
                evt_byte  = buf_rdata;
                evt_last  = at_end;
            end
            ST_BUTTON: begin
                vol_valid = 1'b1;
                vol_level = taps[2];
                bri_req   = bl_enable;
            end
            ST_BL_POWER: begin
                pwr_req = 1'b1;
            end
            default: ;
        endcase
    end

    assign dbg_code = taps[0];
    assign busy     = (st_q != ST_COLLECT);
    assign awaiting = awaiting_q;
    assign pend_clr = pend_clr_q;

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt_q   <= '0;
            len_q      <= '0;
            rd_idx_q   <= '0;
            awaiting_q <= 1'b0;
            pend_clr_q <= 1'b0;
        end else begin
            pend_clr_q <= (st_q == ST_COLLECT) && in_empty && !in_valid && (wr_cnt_q == '0);
            if (st_q == ST_COLLECT && in_valid) begin
                if (in_last) begin
                    len_q    <= wr_cnt_q + LW'(1);
                    wr_cnt_q <= '0;
                end else begin
                    wr_cnt_q <= wr_cnt_q + LW'(1);
                end
            end
            if (st_q == ST_CLASSIFY)
                rd_idx_q <= LW'(1);
            else if (st_q == ST_REPLY || st_q == ST_EVENT)
                rd_idx_q <= rd_idx_q + LW'(1);
            if (await_set)
                awaiting_q <= 1'b1;
            else if (st_q == ST_CLASSIFY && is_bus && !is_auto && awaiting_q)
                awaiting_q <= 1'b0;
        end
    end

    // ---------------- follow-up command slots ----------------
    assign pwr_on_data = lamp_on;

    fu_slot #(.W(DW)) u_bri_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bri_req),
        .req_data  (code),
        .done      (bri_done),
        .cmd_valid (bri_cmd_valid),
        .cmd_data  (bri_cmd_code),
        .in_flight ()
    );

    fu_slot #(.W(1)) u_pwr_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (pwr_req),
        .req_data  (pwr_on_data),
        .done      (pwr_done),
        .cmd_valid (pwr_cmd_valid),
        .cmd_data  (pwr_cmd_on),
        .in_flight ()
    );

    // ---------------- assertions ----------------
    a_r2_reply_clears_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_done && !await_set) |=> !awaiting);

    a_r4_extra_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        err_extra |-> !awaiting);

    a_r3_reply_len_shape: assert property (@(posedge clk) disable iff (!rst_n)
        rep_done |-> (rep_len != LW'(1)));

    a_r5_streams_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rep_valid, evt_valid, vol_valid, dbg_valid, err_extra}));

    a_r7_code_shape: assert property (@(posedge clk) disable iff (!rst_n)
        bri_cmd_valid |-> (bri_cmd_code == OFF_CODE ||
                           (!bri_cmd_code[0] && bri_cmd_code <= BASE_CODE)));

    a_r11_busy_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && in_valid && in_last) |=> busy);
endmodule

// File: tb/tb_irq_pkt_dispatch.sv
module tb_irq_pkt_dispatch;
    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0, in_last = 0, in_empty = 0;
    logic [7:0] in_byte = 0;
    logic await_set = 0, bl_enable = 0, bri_done = 0, pwr_done = 0;
    logic busy, awaiting, pend_clr, err_extra, dbg_valid, rep_valid, rep_done;
    logic evt_valid, evt_last, vol_valid, bri_cmd_valid, pwr_cmd_valid, pwr_cmd_on;
    logic [7:0] dbg_code, rep_byte, evt_byte, vol_level, bri_cmd_code;
    logic [5:0] rep_len;

    always #4 clk = ~clk;

    irq_pkt_dispatch dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_last(in_last), .in_empty(in_empty), .await_set(await_set),
        .bl_enable(bl_enable), .bri_done(bri_done), .pwr_done(pwr_done),
        .busy(busy), .awaiting(awaiting), .pend_clr(pend_clr),
        .err_extra(err_extra), .dbg_valid(dbg_valid), .dbg_code(dbg_code),
        .rep_valid(rep_valid), .rep_byte(rep_byte), .rep_done(rep_done),
        .rep_len(rep_len), .evt_valid(evt_valid), .evt_byte(evt_byte),
        .evt_last(evt_last), .vol_valid(vol_valid), .vol_level(vol_level),
        .bri_cmd_valid(bri_cmd_valid), .bri_cmd_code(bri_cmd_code),
        .pwr_cmd_valid(pwr_cmd_valid), .pwr_cmd_on(pwr_cmd_on)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // monitor counters
    int n_pend, n_err, n_dbg, n_rep, n_done, n_evt, n_evt_last, n_vol, n_bri, n_pwr;
    int last_rep_len, last_dbg, last_vol, last_bri, last_pwr;
    logic [7:0] rep_q [32];
    logic [7:0] evt_q [32];
    logic [7:0] pk [32];

    task automatic clr_mon();
        n_pend = 0; n_err = 0; n_dbg = 0; n_rep = 0; n_done = 0; n_evt = 0;
        n_evt_last = 0; n_vol = 0; n_bri = 0; n_pwr = 0;
        last_rep_len = -1; last_dbg = -1; last_vol = -1; last_bri = -1; last_pwr = -1;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_clr) n_pend++;
            if (err_extra) n_err++;
            if (dbg_valid) begin n_dbg++; last_dbg = dbg_code; end
            if (rep_valid) begin rep_q[n_rep[4:0]] = rep_byte; n_rep++; end
            if (rep_done) begin n_done++; last_rep_len = rep_len; end
            if (evt_valid) begin evt_q[n_evt[4:0]] = evt_byte; n_evt++; end
            if (evt_valid && evt_last) n_evt_last++;
            if (vol_valid) begin n_vol++; last_vol = vol_level; end
            if (bri_cmd_valid) begin n_bri++; last_bri = bri_cmd_code; end
            if (pwr_cmd_valid) begin n_pwr++; last_pwr = pwr_cmd_on; end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1; in_byte = pk[i]; in_last = (i == n - 1);
        end
        @(posedge clk); #1;
        in_valid = 0; in_last = 0;
    endtask

    task automatic settle();
        repeat (40) @(posedge clk);
        @(negedge clk); #1;
    endtask

    task automatic pulse_await();
        @(posedge clk); #1; await_set = 1;
        @(posedge clk); #1; await_set = 0;
    endtask

    task automatic pulse_done(input bit b, input bit p);
        @(posedge clk); #1; bri_done = b; pwr_done = p;
        @(posedge clk); #1; bri_done = 0; pwr_done = 0;
        settle();
    endtask

    task automatic t_reset();
        clr_mon();
        settle();
        chk("R11 reset busy", busy, 0);
        chk("R11 reset awaiting", awaiting, 0);
        chk("R1 reset quiet", n_pend + n_dbg + n_rep + n_evt + n_vol + n_bri, 0);
    endtask

    task automatic t_empty();
        clr_mon();
        @(posedge clk); #1; in_empty = 1;
        @(posedge clk); #1; in_empty = 0;
        settle();
        chk("R1 pend_clr count", n_pend, 1);
        chk("R1 no other output", n_dbg + n_err + n_done + n_evt + n_vol, 0);
    endtask

    task automatic t_reply_long();
        clr_mon();
        pulse_await();
        settle();
        chk("R11 await_set sets awaiting", awaiting, 1);
        pk[0] = 8'h10; pk[1] = 8'hA1; pk[2] = 8'hB2; pk[3] = 8'hC3;
        send(4);
        chk("R11 busy after last byte", busy, 1);
        settle();
        chk("R2 awaiting cleared", awaiting, 0);
        chk("R3 reply byte count", n_rep, 3);
        chk("R3 reply byte 1", rep_q[0], 8'hA1);
        chk("R3 reply byte 3", rep_q[2], 8'hC3);
        chk("R3 rep_len", last_rep_len, 3);
        chk("R3 rep_done count", n_done, 1);
    endtask

    task automatic t_reply_short();
        clr_mon();
        pulse_await();
        pk[0] = 8'h11; pk[1] = 8'h55;
        send(2);
        settle();
        chk("R3 short reply bytes", n_rep, 0);
        chk("R3 short rep_done", n_done, 1);
        chk("R3 short rep_len", last_rep_len, 0);
        chk("R2 short awaiting cleared", awaiting, 0);
    endtask

    task automatic t_extra();
        clr_mon();
        pk[0] = 8'h10; pk[1] = 8'h01; pk[2] = 8'h02;
        send(3);
        settle();
        chk("R4 err_extra", n_err, 1);
        chk("R4 no reply", n_rep + n_done, 0);
        chk("R4 awaiting stays 0", awaiting, 0);
    endtask

    task automatic t_event();
        clr_mon();
        pulse_await();
        pk[0] = 8'h14; pk[1] = 8'h3C; pk[2] = 8'hBD;
        send(3);
        settle();
        chk("R5 event bytes", n_evt, 2);
        chk("R5 event byte 1", evt_q[0], 8'h3C);
        chk("R5 event byte 2", evt_q[1], 8'hBD);
        chk("R5 evt_last once", n_evt_last, 1);
        chk("R5 awaiting unchanged", awaiting, 1);
        chk("R5 no reply", n_done, 0);
        // consume the pending wait
        pk[0] = 8'h10; send(1);
        settle();
    endtask

    task automatic t_button(input logic [7:0] b1, input int exp_code, input int exp_on);
        clr_mon();
        bl_enable = 1;
        pk[0] = 8'h08; pk[1] = b1; pk[2] = 8'h33;
        send(3);
        settle();
        chk("R6 vol_valid", n_vol, 1);
        chk("R6 vol_level", last_vol, 8'h33);
        chk("R8 bri issued", n_bri, 1);
        chk("R7 bri code", last_bri, exp_code);
        chk("R8 pwr issued", n_pwr, 1);
        chk("R8 pwr on", last_pwr, exp_on);
        pulse_done(1, 1);
        chk("R9 no reissue after idle done", n_bri + n_pwr, 2);
    endtask

    task automatic t_button_off();
        clr_mon();
        bl_enable = 0;
        pk[0] = 8'h08; pk[1] = 8'h28; pk[2] = 8'h44;
        send(3);
        settle();
        chk("R6 vol with backlight off", last_vol, 8'h44);
        chk("R8 no commands when disabled", n_bri + n_pwr, 0);
    endtask

    task automatic t_coalesce();
        clr_mon();
        bl_enable = 1;
        pk[0] = 8'h08; pk[2] = 8'h01;
        pk[1] = 8'h08; send(3); settle();
        chk("R9 first bri", n_bri, 1);
        chk("R7 level 1 code", last_bri, 8'h48);
        pk[1] = 8'h10; send(3); settle();
        pk[1] = 8'h18; send(3); settle();
        chk("R9 held while in flight", n_bri, 1);
        chk("R9 pwr held while in flight", n_pwr, 1);
        pulse_done(1, 0);
        chk("R9 newest after done", n_bri, 2);
        chk("R9 newest code", last_bri, 8'h44);
        pulse_done(1, 0);
        chk("R9 nothing more queued", n_bri, 2);
        pulse_done(0, 1);
        chk("R9 pwr queued one", n_pwr, 2);
        pulse_done(0, 1);
        chk("R9 pwr nothing more", n_pwr, 2);
    endtask

    task automatic t_misc();
        clr_mon();
        pk[0] = 8'h80; send(1); settle();
        chk("R10 tick ignored", n_dbg + n_vol + n_evt + n_err, 0);
        pk[0] = 8'h08; send(1); settle();
        chk("R10 short button is debug", n_dbg, 1);
        chk("R10 debug code", last_dbg, 8'h08);
        pk[0] = 8'h80; pk[1] = 8'h00; send(2); settle();
        chk("R10 long tick is debug", n_dbg, 2);
        pk[0] = 8'h08; pk[1] = 8'h10; pk[2] = 8'h10; pk[3] = 8'h00;
        send(4); settle();
        chk("R6 len 4 not a button", n_vol, 0);
        chk("R10 len 4 debug code", last_dbg, 8'h08);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R11 watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clr_mon();
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_empty();
        t_reply_long();
        t_reply_short();
        t_extra();
        t_event();
        t_button(8'h28, 8'h40, 1);
        t_button(8'h07, 8'h7F, 0);
        t_button(8'hF8, 8'h0C, 1);
        t_button_off();
        t_coalesce();
        t_misc();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule